// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog counter with a single 32-bit control word. Software services it by writing that word again. Once the watchdog is enabled, a write is accepted only if it carries the bitwise inverse of the key held from the previous accepted write. The key therefore alternates between two values, and a stray or repeated write cannot feed the dog.

The counter steps down on a slow tick-enable pulse of roughly 760 Hz, produced outside the block. The first time the count runs out, the block raises a non-maskable interrupt and starts a fixed grace countdown. If that grace countdown also runs out before a valid service write arrives, the block emits a one-cycle system reset request. It then waits, with the NMI still raised, until an accepted write arrives.

Control word layout at default parameters:

| Bits | Field |
|---|---|
| [15:9] | key |
| [8] | run/enable |
| [7:0] | count, where 0 means 256 |

Status layout:

| Bits | Field |
|---|---|
| [8:0] | live count |
| [9] | NMI flag |
| [31:10] | zero |

The controller has four states:

- **STOP**: the counter is held.
- **ARMED**: the main countdown is running.
- **GRACE**: the grace countdown is running and the NMI is high.
- **TRIPPED**: the reset request has been issued and the block waits.

Its transitions are:

- **load-run**: an accepted write with bit 8 set moves the block from any state to ARMED.
- **load-stop**: an accepted write with bit 8 clear moves the block from any state to STOP.
- **first-expiry**: ARMED moves to GRACE on a tick while the count is 1.
- **final-expiry**: GRACE moves to TRIPPED on a tick while the count is 1.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control readback is 0, the status readback is 0, and nmi and rst_req are low.
- R2: While control bit 8 is clear, a write is accepted whatever its key, and the control readback becomes the written word on the next cycle.
- R3: While control bit 8 is set, a write whose bits [15:9] differ from the bitwise inverse of control bits [15:9] is ignored: control, count and NMI are left as they were.
- R4: An accepted write loads the count from bits [7:0], and a value of 0 loads 256.
- R5: While in ARMED or GRACE, each cycle with tick high lowers the count by one. While in STOP, or in any cycle without tick, the count holds.
- R6: A tick in ARMED with count 1 raises nmi on the next cycle and loads the count with 10.
- R7: An accepted write drops nmi on the next cycle.
- R8: A tick in GRACE with count 1 gives a single-cycle rst_req pulse on the next cycle and sets the count to 0. After that, count and nmi stay unchanged until an accepted write.
- R9: Status bits [8:0] hold the count, bit 9 holds nmi, and bits [31:10] read 0.
- R10: When an accepted write and a tick fall in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| tick | input | 1 | Slow tick-enable pulse |
| rd_ctrl | output | 32 | Stored control word |
| rd_status | output | 32 | Live count and NMI flag |
| nmi | output | 1 | Non-maskable interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every piece of internal state in this block is visible at the ports one cycle later: the key and run bit appear in rd_ctrl, and the count and the NMI flag appear in rd_status. A controller in the wrong state therefore shows up on the next tick, as a count that moves when it should hold or holds when it should move. A wrong key comparison shows up on the cycle after the write, as a control readback that changed or failed to change. A fault in the escalation path becomes visible at the first expiry, where nmi, the grace reload value of 10 and the rst_req pulse each have exactly one correct cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_STOP    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_GRACE   = 2'd2,
        WD_TRIPPED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7
) (
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              accept,
    output logic              load_run,
    output logic [CNT_W:0]    load_cnt
);
    localparam int EN_BIT = CNT_W;
    localparam int KEY_LO = CNT_W + 1;
    localparam int KEY_HI = CNT_W + KEY_W;

    logic key_ok;

    always_comb begin
        key_ok   = (wr_data[KEY_HI:KEY_LO] == ~ctrl_q[KEY_HI:KEY_LO]);
        accept   = wr_en && (!ctrl_q[EN_BIT] || key_ok);
        load_run = wr_data[EN_BIT];
        if (wr_data[CNT_W-1:0] == '0)
            load_cnt = {1'b1, {CNT_W{1'b0}}};
        else
            load_cnt = {1'b0, wr_data[CNT_W-1:0]};
    end
endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int GRACE = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           accept,
    input  logic           load_run,
    input  logic [CNT_W:0] load_cnt,
    output logic [CNT_W:0] count,
    output logic           nmi,
    output logic           rst_req
);
    localparam logic [CNT_W:0] GRACE_V = (CNT_W + 1)'(GRACE);
    localparam logic [CNT_W:0] ONE_V   = (CNT_W + 1)'(1);

    wd_state_e      st_q, st_d;
    logic [CNT_W:0] cnt_q, cnt_d;
    logic           first_hit, final_hit;

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        first_hit = 1'b0;
        final_hit = 1'b0;
        if (accept) begin
            st_d  = load_run ? WD_ARMED : WD_STOP;
            cnt_d = load_cnt;
        end else if (tick) begin
            unique case (st_q)
                WD_ARMED: begin
                    if (cnt_q == ONE_V) begin
                        first_hit = 1'b1;
                        st_d      = WD_GRACE;
                        cnt_d     = GRACE_V;
                    end else begin
                        cnt_d = cnt_q - ONE_V;
                    end
                end
                WD_GRACE: begin
                    if (cnt_q == ONE_V) begin
                        final_hit = 1'b1;
                        st_d      = WD_TRIPPED;
                        cnt_d     = '0;
                    end else begin
                        cnt_d = cnt_q - ONE_V;
                    end
                end
                WD_STOP, WD_TRIPPED: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WD_STOP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= final_hit;
            if (accept)
                nmi <= 1'b0;
            else if (first_hit)
                nmi <= 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7,
    parameter int GRACE  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic [DATA_W-1:0] rd_ctrl,
    output logic [DATA_W-1:0] rd_status,
    output logic              nmi,
    output logic              rst_req
);
    localparam int PAD_W = DATA_W - CNT_W - 2;

    logic [DATA_W-1:0] ctrl_q;
    logic              accept, load_run;
    logic [CNT_W:0]    load_cnt, count;

    wdg_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_gate (
        .ctrl_q   (ctrl_q),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .accept   (accept),
        .load_run (load_run),
        .load_cnt (load_cnt)
    );

    wdg_fsm #(.CNT_W(CNT_W), .GRACE(GRACE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .accept   (accept),
        .load_run (load_run),
        .load_cnt (load_cnt),
        .count    (count),
        .nmi      (nmi),
        .rst_req  (rst_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (accept)
            ctrl_q <= wr_data;
    end

    assign rd_ctrl   = ctrl_q;
    assign rd_status = {{PAD_W{1'b0}}, nmi, count};
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int KEY_W  = 7,
    parameter int GRACE  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [DATA_W-1:0] rd_ctrl,
    input logic [DATA_W-1:0] rd_status,
    input logic              nmi,
    input logic              rst_req
);
    localparam int EN_BIT = CNT_W;
    localparam int KEY_LO = CNT_W + 1;
    localparam int KEY_HI = CNT_W + KEY_W;
    localparam logic [CNT_W:0] GRACE_V = (CNT_W + 1)'(GRACE);

    logic key_match, wr_ok, wr_bad;
    assign key_match = (wr_data[KEY_HI:KEY_LO] == ~rd_ctrl[KEY_HI:KEY_LO]);
    assign wr_ok     = wr_en && (!rd_ctrl[EN_BIT] || key_match);
    assign wr_bad    = wr_en && rd_ctrl[EN_BIT] && !key_match;

    p_store_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (rd_ctrl == $past(wr_data)));
    p_reject_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> $stable(rd_ctrl));
    p_count_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_data[CNT_W-1:0] != '0) |=> (rd_status[CNT_W:0] == {1'b0, $past(wr_data[CNT_W-1:0])}));
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tick) |=> $stable(rd_status));
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ctrl[EN_BIT] |-> !nmi);
    p_nmi_grace_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> (rd_status[CNT_W:0] == GRACE_V));
    p_nmi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !nmi);
    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    p_rst_after_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (nmi && rd_status[CNT_W:0] == '0));
endmodule

bind keyed_watchdog wdg_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W), .GRACE(GRACE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .rd_ctrl(rd_ctrl), .rd_status(rd_status), .nmi(nmi), .rst_req(rst_req)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_ctrl, rd_status;
    logic        nmi, rst_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_ctrl = '0;
    int          m_cnt = 0;
    bit          m_nmi = 1'b0;
    int          m_ph = 0; // 0 stop, 1 armed, 2 grace, 3 tripped
    bit          m_rst = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
        .rd_ctrl(rd_ctrl), .rd_status(rd_status), .nmi(nmi), .rst_req(rst_req)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input bit run, input logic [7:0] cnt);
        return {16'h0, key, run, cnt};
    endfunction

    function automatic bit key_ok(input logic [31:0] ctrl, input logic [31:0] data);
        return !ctrl[8] || (data[15:9] == ~ctrl[15:9]);
    endfunction

    function automatic logic [31:0] exp_status();
        return {22'h0, m_nmi, 9'(m_cnt)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit w, input logic [31:0] d, input bit t);
        m_rst = 1'b0;
        if (w && key_ok(m_ctrl, d)) begin
            m_ctrl = d;
            m_cnt  = (d[7:0] == 0) ? 256 : int'(d[7:0]);
            m_ph   = d[8] ? 1 : 0;
            m_nmi  = 1'b0;
        end else if (t) begin
            if (m_ph == 1) begin
                if (m_cnt == 1) begin m_cnt = 10; m_nmi = 1'b1; m_ph = 2; end
                else m_cnt = m_cnt - 1;
            end else if (m_ph == 2) begin
                if (m_cnt == 1) begin m_cnt = 0; m_ph = 3; m_rst = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic cycle(input bit w, input logic [31:0] d, input bit t);
        @(negedge clk);
        wr_en = w; wr_data = d; tick = t;
        @(posedge clk);
        model_step(w, d, t);
        #1;
        chk(rd_ctrl == m_ctrl, "R3 ctrl", rd_ctrl, m_ctrl);
        chk(rd_status == exp_status(), "R5 status", rd_status, exp_status());
        chk(nmi == m_nmi, "R6 nmi", 32'(nmi), 32'(m_nmi));
        chk(rst_req == m_rst, "R8 rst_req", 32'(rst_req), 32'(m_rst));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(rd_ctrl == 0, "R1 ctrl", rd_ctrl, 0);
        chk(rd_status == 0, "R1 status", rd_status, 0);
        chk(!nmi && !rst_req, "R1 outputs", {nmi, rst_req}, 0);

        // R2: disabled accepts any key
        cycle(1, mk(7'h2A, 1, 8'd3), 0);
        chk(rd_ctrl == mk(7'h2A, 1, 8'd3), "R2 store", rd_ctrl, mk(7'h2A, 1, 8'd3));
        chk(rd_status == 3, "R4 load", rd_status, 3);
        // R3: wrong key ignored
        cycle(1, mk(7'h2A, 1, 8'd9), 0);
        chk(rd_ctrl == mk(7'h2A, 1, 8'd3) && rd_status == 3, "R3 reject", rd_status, 3);
        // R5 decrement
        cycle(0, 0, 1);
        cycle(0, 0, 1);
        chk(rd_status == 1, "R5 decrement", rd_status, 1);
        // R6 first expiry
        cycle(0, 0, 1);
        chk(nmi && rd_status == 32'h20A, "R6 nmi grace", rd_status, 32'h20A);
        // R10 + R4 zero + R7
        cycle(1, mk(7'h55, 1, 8'd0), 1);
        chk(rd_status == 256, "R4 zero is 256", rd_status, 256);
        chk(!nmi, "R7 nmi cleared", 32'(nmi), 0);
        chk(rd_ctrl == mk(7'h55, 1, 8'd0), "R10 write wins", rd_ctrl, mk(7'h55, 1, 8'd0));
        // R8 escalation
        cycle(1, mk(7'h2A, 1, 8'd2), 0);
        cycle(0, 0, 1);
        cycle(0, 0, 1);
        for (int i = 0; i < 9; i++) cycle(0, 0, 1);
        chk(rd_status == 32'h201 && !rst_req, "R8 before", rd_status, 32'h201);
        cycle(0, 0, 1);
        chk(rst_req && rd_status == 32'h200, "R8 pulse", {31'h0, rst_req}, 1);
        cycle(0, 0, 1);
        chk(!rst_req && rd_status == 32'h200, "R8 tripped hold", rd_status, 32'h200);
        // R5 stop holds, R9 format
        cycle(1, mk(7'h55, 0, 8'd5), 0);
        for (int i = 0; i < 3; i++) cycle(0, 0, 1);
        chk(rd_status == 5, "R9 status format", rd_status, 5);
        chk(!nmi, "R5 stopped hold", 32'(nmi), 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit w, t;
            logic [31:0] d;
            w = ($urandom % 8) == 0;
            t = ($urandom % 2) == 0;
            d = {16'($urandom), 7'($urandom), 1'($urandom), 8'($urandom % 16)};
            if (($urandom % 4) != 0) d[15:9] = ~m_ctrl[15:9];
            if (($urandom % 8) != 0) d[8] = 1'b1;
            cycle(w, d, t);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule